// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for clause-22 station management. Software sets up one transaction through two 32-bit registers on a simple read/write port. It then sets a launch bit. The block produces the management clock on `mdc_o` and shifts a complete 64-bit management frame onto the data line. During a read it releases the line for the PHY and collects the 16 bits the PHY returns. It also reports completion by clearing the launch bit.

Only one transaction runs at a time. A 3-bit range code picks the clock divider, so that the management clock stays slow enough for the PHY whatever the system clock frequency. The codes are not in frequency order. While a transaction runs, the command register is locked.

Top module: `mdio_master`

## Requirements
- R1: The command register is at byte offset 0x10 and the data register at 0x14. The command register reads back as {16'b0, phy[4:0], regnum[4:0], 1'b0, range[2:0], write, busy}, the data register as {16'b0, data[15:0]}, and any other offset reads 0.
- R2: Writing 0x10 with bit 0 set while idle launches a frame. Bit 0 then reads 1 until the end of the 64th MDC period, which falls at 64 × divide ratio clock cycles after the accepting edge. It then reads 0.
- R3: Bit 1 of the command word selects the direction: 1 = write (opcode 01), 0 = read (opcode 10).
- R4: Bits 4:2 select the MDC divide ratio: 0→42, 1→62, 2→16, 3→26, 4→102, 5→124, 6→124, 7→124. MDC is high for the second half of each period.
- R5: Bits 10:6 hold the PHY register number and bits 15:11 the PHY address. Both are sent MSB first.
- R6: The frame is, MSB first: 32 ones, 01, opcode, PHY address, register number, turnaround (10 on a write), and 16 data bits.
- R7: MDIO output changes only at launch or on a falling MDC edge. MDIO input is sampled on each rising MDC edge.
- R8: After a read completes, data[15:0] holds the 16 bits sampled in the data phase, first sample in bit 15.
- R9: A write to 0x10 while busy is ignored. Neither the fields nor the running frame change.
- R10: In idle, MDC, MDIO output and output-enable are low. During the two turnaround bits and the 16 data bits of a read, output-enable is low.
- R11: A write frame sends the data register value latched at launch. Later writes to 0x14 while the frame runs do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench runs reads and writes at several range codes, including the two fallback codes, and compares the clock, data line, enable and registers with its model on every cycle. If a divider ratio were wrong, or codes 6 and 7 did not fall back, the busy window and the MDC edges would drift from the model. A shifter that moved on rising edges, or an enable held high through the read turnaround, would show up as a bit mismatch. A command write during busy, and a data write during a write frame, are issued mid-frame. A design that accepted either would change the serial stream or the command fields read back afterwards. Read data uses an asymmetric pattern, so a reversed capture order fails.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [7:0] CMD_OFS  = 8'h10;
  localparam logic [7:0] DATA_OFS = 8'h14;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX     = 46;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regnum;
    logic [2:0] range;
    logic       wr;
  } cmd_t;

  function automatic int div_ratio(input logic [2:0] code);
    case (code)
      3'd0: return 42;
      3'd1: return 62;
      3'd2: return 16;
      3'd3: return 26;
      3'd4: return 102;
      default: return 124;
    endcase
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          rd_done_i,
  input  logic [15:0]   rd_word_i,
  output cmd_t          cmd_o,
  output cmd_t          launch_cmd_o,
  output logic          launch_o,
  output logic          cmd_hit_o,
  output logic [15:0]   data_o
);
  cmd_t        cmd_q;
  logic [15:0] data_q;
  logic        data_hit;

  assign cmd_hit_o = we_i && (addr_i == AW'(CMD_OFS));
  assign data_hit  = we_i && (addr_i == AW'(DATA_OFS));
  assign launch_cmd_o = '{phy: wdata_i[15:11], regnum: wdata_i[10:6],
                          range: wdata_i[4:2], wr: wdata_i[1]};
  assign launch_o = cmd_hit_o && !busy_i && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_hit_o && !busy_i) cmd_q <= launch_cmd_o;
      if (rd_done_i)            data_q <= rd_word_i;
      else if (data_hit)        data_q <= wdata_i[15:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(CMD_OFS))
      rdata_o[15:0] = {cmd_q.phy, cmd_q.regnum, 1'b0, cmd_q.range, cmd_q.wr, busy_i};
    else if (addr_i == AW'(DATA_OFS))
      rdata_o[15:0] = data_q;
  end

  assign cmd_o  = cmd_q;
  assign data_o = data_q;
endmodule

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
  import mdio_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_i,
  input  logic [2:0] range_i,
  output logic       mdc_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half;
  logic          tick;

  assign half   = CW'(div_ratio(range_i) / 2);
  assign tick   = run_i && (cnt_q == half - CW'(1));
  assign rise_o = tick && !mdc_o;
  assign fall_o = tick && mdc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (run_i) begin
      if (tick) begin
        cnt_q <= '0;
        mdc_o <= ~mdc_o;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int FL = FRAME_BITS,
  localparam int IW = $clog2(FL)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        launch_i,
  input  cmd_t        cmd_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        oe_o,
  output logic        rd_done_o,
  output logic [15:0] rd_word_o
);
  logic [FL-1:0] sr_q;
  logic [IW-1:0] idx_q;
  logic          wr_q;
  logic [15:0]   cap_q;
  logic [FL-1:0] frame;
  logic          last;

  // write: TA driven 10; read: TA and data slots released
  assign frame = {32'hFFFF_FFFF, 2'b01, cmd_i.wr ? 2'b01 : 2'b10,
                  cmd_i.phy, cmd_i.regnum,
                  cmd_i.wr ? 2'b10 : 2'b00,
                  cmd_i.wr ? wdata_i : 16'h0000};

  assign last      = (idx_q == IW'(FL - 1));
  assign oe_o      = busy_o && (wr_q || (idx_q < IW'(TA_IDX)));
  assign mdio_o    = oe_o && sr_q[FL-1];
  assign rd_done_o = busy_o && fall_i && last && !wr_q;
  assign rd_word_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      sr_q   <= '0;
      idx_q  <= '0;
      wr_q   <= 1'b0;
      cap_q  <= '0;
    end else if (launch_i) begin
      busy_o <= 1'b1;
      sr_q   <= frame;
      idx_q  <= '0;
      wr_q   <= cmd_i.wr;
    end else if (busy_o) begin
      if (rise_i && !wr_q && (idx_q >= IW'(TA_IDX + 2)))
        cap_q <= {cap_q[14:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          busy_o <= 1'b0;
          sr_q   <= '0;
          idx_q  <= '0;
        end else begin
          sr_q  <= {sr_q[FL-2:0], 1'b0};
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_we_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  cmd_t        cmd_q, launch_cmd;
  logic        launch, cmd_hit, busy, rise, fall, rd_done;
  logic [15:0] rd_word, data_q;

  mdio_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .busy_i(busy),
    .rd_done_i(rd_done), .rd_word_i(rd_word),
    .cmd_o(cmd_q), .launch_cmd_o(launch_cmd), .launch_o(launch),
    .cmd_hit_o(cmd_hit), .data_o(data_q)
  );

  mdio_clkdiv #(.CW(CW)) u_div (
    .clk_i, .rst_ni,
    .start_i(launch), .run_i(busy), .range_i(cmd_q.range),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame u_frame (
    .clk_i, .rst_ni,
    .launch_i(launch), .cmd_i(launch_cmd), .wdata_i(data_q),
    .rise_i(rise), .fall_i(fall), .mdio_i,
    .busy_o(busy), .mdio_o, .oe_o(mdio_oe_o),
    .rd_done_o(rd_done), .rd_word_o(rd_word)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        oe_i,
  input logic        cmd_hit_i,
  input logic [13:0] cmd_i
);
  AST_MDC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i && !mdio_i && !oe_i); // R10

  AST_END_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(mdc_i)); // R2

  AST_LAUNCH_PREAMBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !mdc_i && oe_i && mdio_i); // R6

  AST_MDIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) && !$fell(mdc_i) |-> $stable(mdio_i) && $stable(oe_i)); // R7

  AST_CMD_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && cmd_hit_i |=> $stable(cmd_i)); // R9
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .mdc_i(mdc_o),
  .mdio_i(mdio_o), .oe_i(mdio_oe_o), .cmd_hit_i(cmd_hit), .cmd_i(cmd_q)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h10;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, moe;
  logic        mdi = 1'b1;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  mdio_master dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi)
  );

  // behavioural model
  bit          m_act;
  int          m_k, m_half;
  bit [63:0]   m_frame;
  bit          m_wr;
  bit [4:0]    m_phy, m_reg;
  bit [2:0]    m_rng;
  bit [15:0]   m_data, m_cap, resp;

  function automatic int ratio(input bit [2:0] c);
    case (c)
      0: return 42; 1: return 62; 2: return 16; 3: return 26; 4: return 102;
      default: return 124;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_k = 0; m_half = 1; m_frame = '0; m_wr = 0;
      m_phy = 0; m_reg = 0; m_rng = 0; m_data = 0; m_cap = 0;
    end else begin
      if (m_act) begin
        int kn, idx;
        kn = m_k + 1;
        if (kn % m_half == 0 && ((kn / m_half) % 2) == 1) begin
          idx = (kn / m_half - 1) / 2;
          if (!m_wr && idx >= 48) m_cap = {m_cap[14:0], mdi};
        end
        m_k = kn;
        if (kn == 128 * m_half) begin
          m_act = 0;
          if (!m_wr) m_data = m_cap;
        end
        if (we && addr == 8'h14) m_data = wdata[15:0];
      end else begin
        if (we && addr == 8'h14) m_data = wdata[15:0];
        if (we && addr == 8'h10) begin
          m_phy = wdata[15:11]; m_reg = wdata[10:6];
          m_rng = wdata[4:2];   m_wr = wdata[1];
          if (wdata[0]) begin
            m_act = 1; m_k = 0; m_half = ratio(m_rng) / 2;
            m_frame = {32'hFFFF_FFFF, 2'b01, m_wr ? 2'b01 : 2'b10, m_phy, m_reg,
                       m_wr ? 2'b10 : 2'b00, m_wr ? m_data : 16'h0};
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, drive PHY response
  always @(negedge clk) begin
    if (rst_n) begin
      int m, idx;
      bit e_mdc, e_oe, e_mdo;
      logic [31:0] e_rd;
      m = m_k / m_half; idx = m / 2;
      e_mdc = m_act && (m % 2 == 1);
      e_oe  = m_act && (m_wr || idx < 46);
      e_mdo = e_oe && m_frame[63 - idx];
      chk("R4 mdc", 32'(mdc), 32'(e_mdc));
      chk("R6 mdio", 32'(mdo), 32'(e_mdo));
      chk("R10 oe", 32'(moe), 32'(e_oe));
      if (addr == 8'h10) e_rd = {16'h0, m_phy, m_reg, 1'b0, m_rng, m_wr, m_act};
      else if (addr == 8'h14) e_rd = {16'h0, m_data};
      else e_rd = '0;
      chk("R1 rdata", rdata, e_rd);
      mdi <= (m_act && !m_wr && idx >= 48) ? resp[15 - (idx - 48)] : 1'b1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 8'h10; wdata = '0;
  endtask

  function automatic logic [31:0] cmd(input bit [4:0] phy, input bit [4:0] rg,
                                      input bit [2:0] rng, input bit w, input bit go);
    return {16'h0, phy, rg, 1'b0, rng, w, go};
  endfunction

  task automatic wait_idle();
    int guard = 0;
    while (m_act && guard < 20000) begin @(negedge clk); guard++; end
    if (guard >= 20000) chk("R2 frame end", 1, 0);
    @(negedge clk);
  endtask

  task automatic peek(input logic [7:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk); addr = a; #1; chk(tag, rdata, exp); @(negedge clk); addr = 8'h10;
  endtask

  initial begin : watchdog
    #700000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int start;
    resp = 16'hC3A5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset mdc/oe", {30'h0, mdc, moe}, 0);
    peek(8'h10, "R1 reset cmd", 0);
    peek(8'h14, "R1 reset data", 0);
    peek(8'h20, "R1 unmapped", 0);

    // R11 R3: write frame, range 2, data write mid-frame must not alter stream
    wr(8'h14, 32'h0000_5A3C);
    wr(8'h10, cmd(5'h11, 5'h1F, 3'd2, 1'b1, 1'b1));
    start = n_cmp;
    repeat (200) @(negedge clk);
    wr(8'h14, 32'h0000_FFFF);               // R11
    wr(8'h10, cmd(5'h02, 5'h03, 3'd0, 1'b0, 1'b1)); // R9 ignored
    wait_idle();
    peek(8'h10, "R9 R5 cmd kept", cmd(5'h11, 5'h1F, 3'd2, 1'b1, 1'b0));

    // R8: read at range 3
    wr(8'h10, cmd(5'h05, 5'h0A, 3'd3, 1'b0, 1'b1));
    wait_idle();
    peek(8'h14, "R8 read data", 32'h0000_C3A5);

    // fields written without launch do not start a frame (R2)
    wr(8'h10, cmd(5'h1E, 5'h01, 3'd1, 1'b0, 1'b0));
    repeat (40) @(negedge clk);
    chk("R2 no launch", 32'(mdc | moe), 0);

    // R4: range 0, 5, 7 fallback, range 4, range 1
    resp = 16'h0F01;
    wr(8'h10, cmd(5'h1F, 5'h00, 3'd0, 1'b0, 1'b1));
    wait_idle();
    peek(8'h14, "R8 read data r0", 32'h0000_0F01);
    wr(8'h14, 32'h0000_8001);
    wr(8'h10, cmd(5'h00, 5'h1F, 3'd7, 1'b1, 1'b1));
    wait_idle();
    wr(8'h10, cmd(5'h0C, 5'h13, 3'd5, 1'b0, 1'b1));
    wait_idle();
    peek(8'h14, "R8 read data r5", 32'h0000_0F01);
    wr(8'h10, cmd(5'h15, 5'h0A, 3'd4, 1'b1, 1'b1));
    wait_idle();
    wr(8'h10, cmd(5'h0A, 5'h15, 3'd6, 1'b0, 1'b1));
    wait_idle();
    wr(8'h10, cmd(5'h01, 5'h02, 3'd1, 1'b1, 1'b1));
    wait_idle();
    peek(8'h10, "R3 R5 final cmd", cmd(5'h01, 5'h02, 3'd1, 1'b1, 1'b0));
    chk("R7 checks ran", 32'(n_cmp > start), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule